// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller moves a small processor system between its running states and three sleep depths. While running, the system either executes from flash (plain run) or from RAM (RAM run), picked by a level input. A one-cycle sleep request, which stands for a wait-for-interrupt or wait-for-event, drops the system into a sleep depth. The depth is chosen from the deep-sleep and shutdown-select flags sampled in the request cycle. The controller drives the core clock gate, the per-peripheral AHB and APB clock gates, the system oscillator select, the halt control of the fast low-power oscillator, a retention indication and a one-cycle shutdown-reset request.

In core-halt only the core clock stops, and any enabled interrupt can wake the system. In clocks-halt both bus clock trees stop and the fast oscillator is suspended. Only the five sources that need no bus clock can wake it, and the return goes through an oscillator restart, then one settling cycle, before the bus clocks come back. In shutdown everything stops. Ordinary interrupts are ignored there, and only an enabled reset source leads back to run. An interrupt wake counts only while the external wake-accepted input is high, which models sufficient interrupt priority. The wake then returns the system to the run state it left.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: After reset the power state is 0 (plain run), the core clock is on, each bus clock equals its enable bit, and osc_sel, lposc_halt, ret_only, shut_rst_req and wake_cause are all 0.
- R2: While running without a sleep request, the power state becomes 1 when ram_sel is high and 0 when it is low, one cycle later; wake and reset-source inputs do not change it.
- R3: A sleep request in a run state selects the state in the next cycle. The choice uses the flags of the request cycle: deep_sel low gives 2 (core-halt), deep_sel high with shut_sel low gives 3 (clocks-halt), and both high give 4 (shutdown).
- R4: In state 2, core_clk_en is 0 and each ahb_clk_en and apb_clk_en bit equals its enable input.
- R5: In state 2, a source with both wake_src and wake_en set, together with wake_ack high, returns the controller to the run state it left, one cycle later; without wake_ack the state holds.
- R6: In state 3, all bus clock gates and the core clock are 0 and lposc_halt is 1. Only wake_src bits 0 to 4 (RTC alarm, RTC oscillator failure, low-power timer, supply low, regulator low) can end it; higher bits are ignored.
- R7: osc_sel is 1 (slow clock) in states 3 and 5 when fast_wake was high at the sleep request, and 0 in every other case.
- R8: A wake in state 3 moves to state 5 with lposc_halt 0 and bus clocks off. State 5 holds until osc_ready, then goes to state 6 with osc_sel 0 and bus clocks still off. One cycle later the controller is back in the run state it left, with clocks on.
- R9: In state 4, every clock gate is 0 and lposc_halt is 1. Interrupt wakes are ignored, and the state is left, to state 0, only when some rst_src bit has its rst_cfg bit set.
- R10: On leaving shutdown, shut_rst_req is high for exactly the first run cycle and ret_only becomes 1; ret_only stays until the next sleep request, which clears it.
- R11: wake_cause holds a one-hot vector of the lowest-index qualifying source that ended the last interrupt wake. It keeps that value until the next wake and is cleared to 0 on a shutdown exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | One-cycle sleep request (WFI/WFE equivalent) |
| deep_sel | input | 1 | Deep-sleep flag |
| shut_sel | input | 1 | Shutdown-select flag |
| ram_sel | input | 1 | Run from RAM when high |
| fast_wake | input | 1 | Fast-wake option for clocks-halt |
| ahb_en | input | N_AHB | Per-peripheral AHB clock enables |
| apb_en | input | N_APB | Per-peripheral APB clock enables |
| wake_src | input | N_WAKE | Wake source levels; bits 0..4 need no bus clock |
| wake_en | input | N_WAKE | Wake source enables |
| wake_ack | input | 1 | Wake accepted (priority sufficient) |
| osc_ready | input | 1 | Fast low-power oscillator has restarted |
| rst_src | input | N_RST | Reset source events |
| rst_cfg | input | N_RST | Reset sources allowed to leave shutdown |
| core_clk_en | output | 1 | Core clock gate |
| ahb_clk_en | output | N_AHB | AHB clock gates |
| apb_clk_en | output | N_APB | APB clock gates |
| osc_sel | output | 1 | 1 selects the slow clock, 0 the fast oscillator |
| lposc_halt | output | 1 | Suspends the fast low-power oscillator |
| ret_only | output | 1 | Only retention memory is preserved |
| shut_rst_req | output | 1 | Reset request on shutdown exit |
| pwr_state | output | 3 | Current power state code |
| wake_cause | output | N_WAKE | One-hot sticky cause of the last wake |

## Verification
The bench targets clocks-halt with only bus-clocked sources asserted. A controller that lets those through would wake from a state whose interrupt logic has no clock. It holds osc_ready low during the restart and checks the settling cycle, which catches a controller that turns the bus clocks on before or together with the oscillator switch. In shutdown it raises every interrupt and reset sources whose enables are clear, which exposes an exit on an interrupt or on the wrong reset bit. It also drops wake_ack while a source is pending, and checks that the wake returns to RAM run and not to plain run.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power sequencing controller.
// Assumes wake sources 0..NOCLK_SRCS-1 are the ones that need no bus clock.
package lpm_pkg;
    typedef enum logic [2:0] {
        PS_RUN        = 3'd0,
        PS_RAM        = 3'd1,
        PS_CORE_HALT  = 3'd2,
        PS_CLK_HALT   = 3'd3,
        PS_SHUT       = 3'd4,
        PS_OSC_SWITCH = 3'd5,
        PS_BUS_RESUME = 3'd6
    } pwr_state_e;

    localparam int unsigned NOCLK_SRCS = 5;
endpackage

// File: rtl/lpm_wake_qual.sv
// Qualifies wake and reset sources.
// Produces "any" flags and lowest-index one-hot picks for the full source set
// and for the subset that needs no bus clock, plus the shutdown reset hit.
// Assumes N_WAKE >= NOCLK_SRCS.
module lpm_wake_qual
    import lpm_pkg::*;
#(
    parameter int unsigned N_WAKE = 8,
    parameter int unsigned N_RST  = 4
) (
    input  logic [N_WAKE-1:0] wake_src,
    input  logic [N_WAKE-1:0] wake_en,
    input  logic [N_RST-1:0]  rst_src,
    input  logic [N_RST-1:0]  rst_cfg,
    output logic              any_clk_wake,
    output logic              any_noclk_wake,
    output logic [N_WAKE-1:0] pick_clk,
    output logic [N_WAKE-1:0] pick_noclk,
    output logic              rst_hit
);
    logic [N_WAKE-1:0] noclk_mask;
    logic [N_WAKE-1:0] armed;
    logic [N_WAKE-1:0] armed_noclk;

    // Build the mask of sources usable while bus clocks are stopped.
    for (genvar g = 0; g < N_WAKE; g++) begin : g_mask
        assign noclk_mask[g] = (g < NOCLK_SRCS);
    end

    // Keep only the lowest set bit of a vector.
    function automatic logic [N_WAKE-1:0] lowest_bit(input logic [N_WAKE-1:0] v);
        logic [N_WAKE-1:0] r;
        r = '0;
        for (int i = N_WAKE - 1; i >= 0; i--) begin
            if (v[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    // Combine sources with enables and derive the picks.
    always_comb begin
        armed          = wake_src & wake_en;
        armed_noclk    = armed & noclk_mask;
        any_clk_wake   = |armed;
        any_noclk_wake = |armed_noclk;
        pick_clk       = lowest_bit(armed);
        pick_noclk     = lowest_bit(armed_noclk);
        rst_hit        = |(rst_src & rst_cfg);
    end
endmodule

// File: rtl/lpm_pwr_fsm.sv
// Power state sequencer.
// Holds the current state, the run state to return to, the latched fast-wake
// choice, the sticky wake cause, the retention flag and the reset pulse.
// Assumes sleep_req is a single-cycle pulse and is only honoured in run states.
module lpm_pwr_fsm
    import lpm_pkg::*;
#(
    parameter int unsigned N_WAKE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              deep_sel,
    input  logic              shut_sel,
    input  logic              ram_sel,
    input  logic              fast_wake,
    input  logic              wake_ack,
    input  logic              osc_ready,
    input  logic              any_clk_wake,
    input  logic              any_noclk_wake,
    input  logic [N_WAKE-1:0] pick_clk,
    input  logic [N_WAKE-1:0] pick_noclk,
    input  logic              rst_hit,
    output pwr_state_e        state_q,
    output logic              fw_q,
    output logic [N_WAKE-1:0] cause_q,
    output logic              ret_only_q,
    output logic              shut_rst_q
);
    pwr_state_e        state_d, back_q, back_d;
    logic              fw_d, ret_only_d, shut_rst_d;
    logic [N_WAKE-1:0] cause_d;

    // Pick the depth for a sleep request from the flags of that cycle.
    function automatic pwr_state_e sleep_depth(input logic deep, input logic shut);
        if (deep && shut) return PS_SHUT;
        if (deep)         return PS_CLK_HALT;
        return PS_CORE_HALT;
    endfunction

    // Next-state and side-effect decisions.
    always_comb begin
        state_d    = state_q;
        back_d     = back_q;
        fw_d       = fw_q;
        cause_d    = cause_q;
        ret_only_d = ret_only_q;
        shut_rst_d = 1'b0;
        case (state_q)
            PS_RUN, PS_RAM: begin
                if (sleep_req) begin
                    back_d     = state_q;
                    fw_d       = fast_wake;
                    ret_only_d = 1'b0;
                    state_d    = sleep_depth(deep_sel, shut_sel);
                end else begin
                    state_d = ram_sel ? PS_RAM : PS_RUN;
                end
            end
            PS_CORE_HALT: begin
                if (wake_ack && any_clk_wake) begin
                    state_d = back_q;
                    cause_d = pick_clk;
                end
            end
            PS_CLK_HALT: begin
                if (wake_ack && any_noclk_wake) begin
                    state_d = PS_OSC_SWITCH;
                    cause_d = pick_noclk;
                end
            end
            PS_OSC_SWITCH: begin
                if (osc_ready) state_d = PS_BUS_RESUME;
            end
            PS_BUS_RESUME: begin
                state_d = back_q;
            end
            PS_SHUT: begin
                if (rst_hit) begin
                    state_d    = PS_RUN;
                    back_d     = PS_RUN;
                    fw_d       = 1'b0;
                    cause_d    = '0;
                    ret_only_d = 1'b1;
                    shut_rst_d = 1'b1;
                end
            end
            default: state_d = PS_RUN;
        endcase
    end

    // State and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PS_RUN;
            back_q     <= PS_RUN;
            fw_q       <= 1'b0;
            cause_q    <= '0;
            ret_only_q <= 1'b0;
            shut_rst_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            back_q     <= back_d;
            fw_q       <= fw_d;
            cause_q    <= cause_d;
            ret_only_q <= ret_only_d;
            shut_rst_q <= shut_rst_d;
        end
    end
endmodule

// File: rtl/lpm_clk_ctl.sv
// Decodes the registered power state into clock gates and oscillator controls.
// Assumes the state input is a register output, so the gates are glitch-free
// decodes of one flop set.
module lpm_clk_ctl
    import lpm_pkg::*;
#(
    parameter int unsigned N_AHB = 3,
    parameter int unsigned N_APB = 6
) (
    input  pwr_state_e       state_q,
    input  logic             fw_q,
    input  logic [N_AHB-1:0] ahb_en,
    input  logic [N_APB-1:0] apb_en,
    output logic             core_clk_en,
    output logic [N_AHB-1:0] ahb_clk_en,
    output logic [N_APB-1:0] apb_clk_en,
    output logic             osc_sel,
    output logic             lposc_halt
);
    logic core_on;
    logic bus_on;

    // Classify the state into core and bus clock domains.
    always_comb begin
        core_on    = (state_q == PS_RUN) || (state_q == PS_RAM);
        bus_on     = core_on || (state_q == PS_CORE_HALT);
        osc_sel    = fw_q && ((state_q == PS_CLK_HALT) || (state_q == PS_OSC_SWITCH));
        lposc_halt = (state_q == PS_CLK_HALT) || (state_q == PS_SHUT);
    end

    assign core_clk_en = core_on;

    // One gate per AHB peripheral.
    for (genvar g = 0; g < N_AHB; g++) begin : g_ahb
        assign ahb_clk_en[g] = bus_on & ahb_en[g];
    end

    // One gate per APB peripheral.
    for (genvar g = 0; g < N_APB; g++) begin : g_apb
        assign apb_clk_en[g] = bus_on & apb_en[g];
    end
endmodule

// File: rtl/lpm_seq_ctrl.sv
// Top of the low-power sequencing controller.
// Connects source qualification, the state sequencer and the clock decode.
// Assumes all inputs are synchronous to clk.
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int unsigned N_AHB  = 3,
    parameter int unsigned N_APB  = 6,
    parameter int unsigned N_WAKE = 8,
    parameter int unsigned N_RST  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              deep_sel,
    input  logic              shut_sel,
    input  logic              ram_sel,
    input  logic              fast_wake,
    input  logic [N_AHB-1:0]  ahb_en,
    input  logic [N_APB-1:0]  apb_en,
    input  logic [N_WAKE-1:0] wake_src,
    input  logic [N_WAKE-1:0] wake_en,
    input  logic              wake_ack,
    input  logic              osc_ready,
    input  logic [N_RST-1:0]  rst_src,
    input  logic [N_RST-1:0]  rst_cfg,
    output logic              core_clk_en,
    output logic [N_AHB-1:0]  ahb_clk_en,
    output logic [N_APB-1:0]  apb_clk_en,
    output logic              osc_sel,
    output logic              lposc_halt,
    output logic              ret_only,
    output logic              shut_rst_req,
    output logic [2:0]        pwr_state,
    output logic [N_WAKE-1:0] wake_cause
);
    logic              any_clk_wake, any_noclk_wake, rst_hit, fw_q;
    logic [N_WAKE-1:0] pick_clk, pick_noclk;
    pwr_state_e        state_q;

    lpm_wake_qual #(.N_WAKE(N_WAKE), .N_RST(N_RST)) i_qual (
        .wake_src       (wake_src),
        .wake_en        (wake_en),
        .rst_src        (rst_src),
        .rst_cfg        (rst_cfg),
        .any_clk_wake   (any_clk_wake),
        .any_noclk_wake (any_noclk_wake),
        .pick_clk       (pick_clk),
        .pick_noclk     (pick_noclk),
        .rst_hit        (rst_hit)
    );

    lpm_pwr_fsm #(.N_WAKE(N_WAKE)) i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sleep_req      (sleep_req),
        .deep_sel       (deep_sel),
        .shut_sel       (shut_sel),
        .ram_sel        (ram_sel),
        .fast_wake      (fast_wake),
        .wake_ack       (wake_ack),
        .osc_ready      (osc_ready),
        .any_clk_wake   (any_clk_wake),
        .any_noclk_wake (any_noclk_wake),
        .pick_clk       (pick_clk),
        .pick_noclk     (pick_noclk),
        .rst_hit        (rst_hit),
        .state_q        (state_q),
        .fw_q           (fw_q),
        .cause_q        (wake_cause),
        .ret_only_q     (ret_only),
        .shut_rst_q     (shut_rst_req)
    );

    lpm_clk_ctl #(.N_AHB(N_AHB), .N_APB(N_APB)) i_clk (
        .state_q     (state_q),
        .fw_q        (fw_q),
        .ahb_en      (ahb_en),
        .apb_en      (apb_en),
        .core_clk_en (core_clk_en),
        .ahb_clk_en  (ahb_clk_en),
        .apb_clk_en  (apb_clk_en),
        .osc_sel     (osc_sel),
        .lposc_halt  (lposc_halt)
    );

    assign pwr_state = state_q;
endmodule

// File: rtl/lpm_seq_ctrl_chk.sv
// Property checker for lpm_seq_ctrl, attached by bind.
// Observes only the top-level ports.
module lpm_seq_ctrl_chk
    import lpm_pkg::*;
#(
    parameter int unsigned N_AHB  = 3,
    parameter int unsigned N_APB  = 6,
    parameter int unsigned N_WAKE = 8,
    parameter int unsigned N_RST  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_req,
    input logic              deep_sel,
    input logic              shut_sel,
    input logic [N_AHB-1:0]  ahb_en,
    input logic [N_APB-1:0]  apb_en,
    input logic [N_WAKE-1:0] wake_src,
    input logic [N_WAKE-1:0] wake_en,
    input logic              wake_ack,
    input logic [N_RST-1:0]  rst_src,
    input logic [N_RST-1:0]  rst_cfg,
    input logic              core_clk_en,
    input logic [N_AHB-1:0]  ahb_clk_en,
    input logic [N_APB-1:0]  apb_clk_en,
    input logic              lposc_halt,
    input logic              shut_rst_req,
    input logic [2:0]        pwr_state,
    input logic [N_WAKE-1:0] wake_cause
);
    localparam logic [N_WAKE-1:0] NOCLK_MASK = N_WAKE'((1 << NOCLK_SRCS) - 1);

    logic in_run;
    assign in_run = (pwr_state == PS_RUN) || (pwr_state == PS_RAM);

    assert_shut_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && sleep_req && deep_sel && shut_sel) |=> (pwr_state == PS_SHUT));

    assert_core_halt_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_CORE_HALT) |->
            (!core_clk_en && ahb_clk_en == ahb_en && apb_clk_en == apb_en));

    assert_no_ack_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_CORE_HALT && !wake_ack) |=> (pwr_state == PS_CORE_HALT));

    assert_clk_halt_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_CLK_HALT) |->
            (!core_clk_en && ahb_clk_en == '0 && apb_clk_en == '0 && lposc_halt));

    assert_clk_halt_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_CLK_HALT && (wake_src & wake_en & NOCLK_MASK) == '0)
            |=> (pwr_state == PS_CLK_HALT));

    assert_resume_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_BUS_RESUME) |=> (pwr_state == PS_RUN || pwr_state == PS_RAM));

    assert_shut_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_SHUT) |->
            (!core_clk_en && ahb_clk_en == '0 && apb_clk_en == '0 && lposc_halt));

    assert_shut_stay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_SHUT && (rst_src & rst_cfg) == '0) |=> (pwr_state == PS_SHUT));

    assert_rst_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        shut_rst_req |=> !shut_rst_req);

    assert_cause_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wake_cause));
endmodule

bind lpm_seq_ctrl lpm_seq_ctrl_chk #(
    .N_AHB(N_AHB), .N_APB(N_APB), .N_WAKE(N_WAKE), .N_RST(N_RST)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .deep_sel     (deep_sel),
    .shut_sel     (shut_sel),
    .ahb_en       (ahb_en),
    .apb_en       (apb_en),
    .wake_src     (wake_src),
    .wake_en      (wake_en),
    .wake_ack     (wake_ack),
    .rst_src      (rst_src),
    .rst_cfg      (rst_cfg),
    .core_clk_en  (core_clk_en),
    .ahb_clk_en   (ahb_clk_en),
    .apb_clk_en   (apb_clk_en),
    .lposc_halt   (lposc_halt),
    .shut_rst_req (shut_rst_req),
    .pwr_state    (pwr_state),
    .wake_cause   (wake_cause)
);

// File: tb/test_lpm_seq_ctrl.sv
// Self-checking bench: fixed-seed random sleep/wake rounds plus directed cases.
module test_lpm_seq_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NA = 3, NP = 6, NW = 8, NR = 4;
    localparam logic [NW-1:0] LOWM = 8'h1F;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          sleep_req = 0, deep_sel = 0, shut_sel = 0, ram_sel = 0, fast_wake = 0;
    logic [NA-1:0] ahb_en = '0;
    logic [NP-1:0] apb_en = '0;
    logic [NW-1:0] wake_src = '0, wake_en = '0;
    logic          wake_ack = 0, osc_ready = 0;
    logic [NR-1:0] rst_src = '0, rst_cfg = '0;
    logic          core_clk_en, osc_sel, lposc_halt, ret_only, shut_rst_req;
    logic [NA-1:0] ahb_clk_en;
    logic [NP-1:0] apb_clk_en;
    logic [2:0]    pwr_state;
    logic [NW-1:0] wake_cause;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lpm_seq_ctrl #(.N_AHB(NA), .N_APB(NP), .N_WAKE(NW), .N_RST(NR)) i_lpm_seq_ctrl (.*);

    function automatic logic [2:0] exp_depth(input bit d, input bit s);
        if (d && s) return 3'd4;
        if (d) return 3'd3;
        return 3'd2;
    endfunction

    function automatic logic [NW-1:0] exp_pick(input logic [NW-1:0] v);
        for (int i = 0; i < NW; i++) if (v[i]) return NW'(1) << i;
        return '0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_src();
        wake_src = '0; wake_ack = 0; osc_ready = 0; rst_src = '0; sleep_req = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(5.0 * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        ahb_en = 3'b101; apb_en = 6'b110011;
        tick(); tick();
        rst_n = 1;
        #1;
        // R1 reset state
        check("R1 state", pwr_state, 0);
        check("R1 core", core_clk_en, 1);
        check("R1 ahb", ahb_clk_en, ahb_en);
        check("R1 apb", apb_clk_en, apb_en);
        check("R1 osc", {osc_sel, lposc_halt, ret_only, shut_rst_req}, 0);
        check("R1 cause", wake_cause, 0);

        // R2: wake and reset sources ignored while running
        wake_src = '1; wake_en = '1; wake_ack = 1; rst_src = '1; rst_cfg = '1;
        tick();
        check("R2 run ignores sources", pwr_state, 0);
        check("R11 no cause in run", wake_cause, 0);
        clear_src();

        for (int it = 0; it < 60; it++) begin
            bit ram, d, s, fw;
            int k;
            logic [2:0] back;
            logic [NW-1:0] armed;
            ram = $urandom_range(0, 1);
            d  = $urandom_range(0, 1);
            s  = ($urandom_range(0, 2) == 0);
            fw = $urandom_range(0, 1);
            ahb_en = NA'($urandom); apb_en = NP'($urandom);
            ram_sel = ram;
            tick();
            check("R2 run select", pwr_state, {2'b0, ram});
            back = {2'b0, ram};
            deep_sel = d; shut_sel = s; fast_wake = fw; sleep_req = 1;
            tick();
            sleep_req = 0; deep_sel = $urandom_range(0, 1); shut_sel = $urandom_range(0, 1);
            check("R3 depth", pwr_state, exp_depth(d, s));
            check("R10 ret_only cleared", ret_only, 0);
            if (!d) begin
                check("R4 core off", core_clk_en, 0);
                check("R4 ahb follow", ahb_clk_en, ahb_en);
                check("R4 apb follow", apb_clk_en, apb_en);
                wake_en = NW'($urandom);
                k = $urandom_range(0, NW - 1);
                wake_en[k] = 1'b1;
                wake_src = NW'($urandom) | (NW'(1) << k);
                wake_ack = 0;
                tick();
                check("R5 hold without ack", pwr_state, 2);
                wake_ack = 1;
                armed = wake_src & wake_en;
                tick();
                clear_src();
                check("R5 return", pwr_state, back);
                check("R11 cause", wake_cause, exp_pick(armed));
                check("R7 osc after core-halt", osc_sel, 0);
            end else if (!s) begin
                check("R6 bus off", {core_clk_en, ahb_clk_en, apb_clk_en}, 0);
                check("R6 lposc halted", lposc_halt, 1);
                check("R7 slow clock", osc_sel, fw);
                wake_en = '1; wake_ack = 1;
                wake_src = NW'($urandom) & ~LOWM;
                tick();
                check("R6 clocked source ignored", pwr_state, 3);
                k = $urandom_range(0, 4);
                wake_src = (NW'($urandom) & ~LOWM) | (NW'(1) << k);
                armed = wake_src & LOWM;
                tick();
                clear_src();
                check("R8 to switch", pwr_state, 5);
                check("R8 lposc running", lposc_halt, 0);
                check("R8 bus off in switch", {ahb_clk_en, apb_clk_en}, 0);
                check("R7 slow during switch", osc_sel, fw);
                tick();
                check("R8 wait osc_ready", pwr_state, 5);
                osc_ready = 1;
                tick();
                osc_ready = 0;
                check("R8 resume cycle", pwr_state, 6);
                check("R8 fast osc selected", osc_sel, 0);
                check("R8 bus still off", {core_clk_en, ahb_clk_en, apb_clk_en}, 0);
                tick();
                check("R8 return", pwr_state, back);
                check("R8 core on", core_clk_en, 1);
                check("R8 ahb on", ahb_clk_en, ahb_en);
                check("R11 cause low", wake_cause, exp_pick(armed));
            end else begin
                check("R9 all off", {core_clk_en, ahb_clk_en, apb_clk_en}, 0);
                check("R9 lposc halted", lposc_halt, 1);
                wake_src = '1; wake_en = '1; wake_ack = 1;
                tick();
                check("R9 interrupts ignored", pwr_state, 4);
                rst_cfg = NR'($urandom) | NR'(1);
                rst_src = ~rst_cfg;
                tick();
                check("R9 disabled reset ignored", pwr_state, 4);
                k = $urandom_range(0, NR - 1);
                rst_cfg[k] = 1'b1;
                rst_src = NR'(1) << k;
                tick();
                clear_src();
                check("R9 exit to run", pwr_state, 0);
                check("R10 reset pulse", shut_rst_req, 1);
                check("R10 retention flag", ret_only, 1);
                check("R11 cause cleared", wake_cause, 0);
                tick();
                check("R10 pulse one cycle", shut_rst_req, 0);
                check("R10 retention held", ret_only, 1);
            end
        end
        finish_run();
    end
endmodule